// File: doc/BRIEF.md
# Clause-22 Management Frame Master

This block runs the two-wire station management link to an Ethernet PHY. A host loads one command: a direction flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. It then pulses `req`. The block drives a complete clause-22 frame on the management clock and data lines. A read hands the data line to the PHY for the turnaround field and the 16 data bits. `idle` falls for the length of the frame and rises again when the frame is done. On a read, the captured halfword is then visible on `rd_data`.

The management clock comes from the system clock through a divider. A 2-bit range code picks one of four ratios to suit the system clock frequency: 8 up to 20 MHz, 16 up to 40 MHz, 32 up to 80 MHz, and 64 above 80 MHz. The block honours requests only while `port_en` is high. Requests made while a frame is in flight are dropped.

Top module: `mdio_master`

## Requirements
- R1: After reset and between frames, `idle` is 1, `mdc` is 0 and `mdio_oe` is 0 (line released).
- R2: `req` is accepted only when `port_en` is 1 and `idle` is 1. A `req` made with `port_en` at 0 leaves `idle` at 1 and starts no clocking.
- R3: A `req` raised while a frame is in flight is ignored. `idle` stays 0 and the frame in flight continues unchanged.
- R4: The `mdc` period is 8, 16, 32 or 64 system cycles for `clk_range` codes 0, 1, 2 and 3. The code is latched at acceptance. Each period is low for its first half and high for its second half.
- R5: The frame has 64 bits, sent MSB first. It is 32 ones, then start 01, then opcode (10 for read, 01 for write), then the PHY address, then the register address, then the turnaround, then 16 data bits. A new bit appears on `mdio_o` as `mdc` falls.
- R6: On a write (`rd_nwr`=0), `mdio_oe` stays 1 for all 64 bits. The turnaround is driven as 10, followed by `wr_data`.
- R7: On a read (`rd_nwr`=1), `mdio_oe` is 1 for bits 0 to 45 and 0 from the first turnaround bit (bit 46) to the end of the frame.
- R8: On a read, `mdio_i` is sampled in the cycle `mdc` rises during each of bits 48 to 63, MSB first. `rd_data` takes the 16 sampled bits as the frame ends. A write leaves `rd_data` unchanged.
- R9: `idle` is 0 from the cycle after acceptance for exactly 64 `mdc` periods, then returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Management port enable |
| clk_range | input | 2 | Divider select: 0=/8, 1=/16, 2=/32, 3=/64 |
| req | input | 1 | Start a frame (single-cycle pulse) |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Write data |
| mdio_i | input | 1 | Data line as seen at the pad |
| rd_data | output | 16 | Last read result |
| idle | output | 1 | 1 when no frame is in flight |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line drive enable |

## Verification
Every output is registered. The edge that accepts a request is counted as cycle 0. After cycle k, `mdc` equals ((k mod P) >= P/2), the bit on the line is k/P, and `idle` comes back exactly at k = 64*P. The bench holds a reference model that counts k from acceptance and derives each expected value arithmetically. Outputs are compared on the falling clock edge after every rising edge, so each value is checked in the cycle it is due. The PHY stand-in changes `mdio_i` on falling edges only. Each sampled bit is then stable at the rising edge where `mdc` goes high, and the expected `rd_data` is the pattern the stand-in sent.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_BIT     = 46;
  localparam int DATA_BIT   = 48;
  localparam int BIT_W      = $clog2(FRAME_BITS);

  // half-period in system cycles for a range code, smallest ratio 2**min_log2
  function automatic int unsigned half_cycles(input logic [1:0] code, input int min_log2);
    return 32'(1) << (min_log2 - 1 + int'(code));
  endfunction
endpackage

// File: rtl/mdio_div_sel.sv
module mdio_div_sel #(
  parameter int MIN_LOG2 = 3,
  parameter int HALF_W   = 6
) (
  input  logic [1:0]        clk_range,
  output logic [HALF_W-1:0] half
);
  always_comb half = HALF_W'(mdio_pkg::half_cycles(clk_range, MIN_LOG2));
endmodule

// File: rtl/mdio_edge_timer.sv
module mdio_edge_timer #(
  parameter int HALF_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              mdc,
  output logic              rise,
  output logic              fall
);
  logic [HALF_W-1:0] cnt;
  logic              wrap;

  assign wrap = run && (cnt == half - HALF_W'(1));
  assign rise = wrap && !mdc;
  assign fall = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + HALF_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int HALF_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en,
  input  logic              req,
  input  logic              rd_nwr,
  input  logic [4:0]        phy_addr,
  input  logic [4:0]        reg_addr,
  input  logic [15:0]       wr_data,
  input  logic [HALF_W-1:0] half_in,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdio_i,
  output logic [HALF_W-1:0] half_q,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [15:0]       rd_data
);
  logic [FRAME_BITS-1:0] shreg;
  logic [FRAME_BITS-1:0] frame;
  logic [BIT_W-1:0]      bit_cnt;
  logic [BIT_W-1:0]      bit_nxt;
  logic                  is_rd;
  logic [15:0]           cap;
  logic                  accept;

  assign accept  = req && port_en && !busy;
  assign bit_nxt = bit_cnt + BIT_W'(1);

  always_comb begin
    frame = {{32{1'b1}}, 2'b01, (rd_nwr ? 2'b10 : 2'b01), phy_addr, reg_addr,
             2'b10, (rd_nwr ? 16'h0000 : wr_data)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      bit_cnt <= '0;
      shreg   <= '0;
      is_rd   <= 1'b0;
      cap     <= '0;
      rd_data <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      half_q  <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      bit_cnt <= '0;
      shreg   <= frame;
      is_rd   <= rd_nwr;
      mdio_o  <= frame[FRAME_BITS-1];
      mdio_oe <= 1'b1;
      half_q  <= half_in;
    end else if (busy) begin
      if (rise && is_rd && bit_cnt >= BIT_W'(DATA_BIT))
        cap <= {cap[14:0], mdio_i};
      if (fall) begin
        if (bit_cnt == BIT_W'(FRAME_BITS - 1)) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          if (is_rd) rd_data <= cap;
        end else begin
          bit_cnt <= bit_nxt;
          shreg   <= shreg << 1;
          mdio_o  <= shreg[FRAME_BITS-2];
          mdio_oe <= !(is_rd && bit_nxt >= BIT_W'(TA_BIT));
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int MIN_LOG2 = 3,
  parameter int HALF_W   = MIN_LOG2 + 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        port_en,
  input  logic [1:0]  clk_range,
  input  logic        req,
  input  logic        rd_nwr,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  input  logic        mdio_i,
  output logic [15:0] rd_data,
  output logic        idle,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic [HALF_W-1:0] half_sel;
  logic [HALF_W-1:0] half_q;
  logic              busy;
  logic              rise;
  logic              fall;

  mdio_div_sel #(.MIN_LOG2(MIN_LOG2), .HALF_W(HALF_W)) u_div (
    .clk_range(clk_range), .half(half_sel)
  );

  mdio_edge_timer #(.HALF_W(HALF_W)) u_tmr (
    .clk(clk), .rst(rst), .run(busy), .half(half_q),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame_engine #(.HALF_W(HALF_W)) u_eng (
    .clk(clk), .rst(rst), .port_en(port_en), .req(req), .rd_nwr(rd_nwr),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .half_in(half_sel), .rise(rise), .fall(fall), .mdio_i(mdio_i),
    .half_q(half_q), .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_data(rd_data)
  );

  assign idle = !busy;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        port_en,
  input logic        req,
  input logic        idle,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [15:0] rd_data
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    idle |-> (!mdc && !mdio_oe));

  // R2
  gated_req_chk: assert property (@(posedge clk) disable iff (rst)
    (idle && req && !port_en) |=> idle);

  // R5
  preamble_start_chk: assert property (@(posedge clk) disable iff (rst)
    (idle && req && port_en) |=> (!idle && mdio_oe && mdio_o && !mdc));

  // R7
  release_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mdio_oe) |-> $fell(mdc));

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(idle) |-> $stable(rd_data));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst(rst), .port_en(port_en), .req(req), .idle(idle),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data)
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic port_en = 1'b0;
  logic [1:0] clk_range = 2'd0;
  logic req = 1'b0;
  logic rd_nwr = 1'b0;
  logic [4:0] phy_addr = '0;
  logic [4:0] reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic mdio_i = 1'b1;
  logic [15:0] rd_data;
  logic idle, mdc, mdio_o, mdio_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  int k = -1;
  int dv = 8;
  logic m_rd = 1'b0;
  logic [63:0] m_frame = '0;
  logic [15:0] m_cap = '0;
  logic [15:0] exp_rd = '0;
  logic [15:0] phy_pat = 16'h0000;

  always #2.5 clk = ~clk;

  mdio_master u0 (
    .clk(clk), .rst(rst), .port_en(port_en), .clk_range(clk_range), .req(req),
    .rd_nwr(rd_nwr), .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .mdio_i(mdio_i), .rd_data(rd_data), .idle(idle), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      k = -1;
      exp_rd = '0;
    end else if (k >= 0) begin
      k = k + 1;
      if (m_rd && (k / dv) >= 48 && (k % dv) == dv / 2) m_cap = {m_cap[14:0], mdio_i};
      if (k == 64 * dv) begin
        if (m_rd) exp_rd = m_cap;
        k = -1;
      end
    end else if (req && port_en) begin
      k = 0;
      dv = 8 << clk_range;
      m_rd = rd_nwr;
      m_frame = {32'hFFFF_FFFF, 2'b01, (rd_nwr ? 2'b10 : 2'b01), phy_addr, reg_addr,
                 2'b10, (rd_nwr ? 16'h0000 : wr_data)};
    end
  end

  // per-cycle comparison and PHY stand-in
  always @(negedge clk) begin
    if (!rst) begin
      if (k < 0) begin
        check(idle == 1'b1, "R9", int'(idle), 1);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1", int'({mdc, mdio_oe}), 0);
        check(rd_data == exp_rd, "R8", int'(rd_data), int'(exp_rd));
        mdio_i = 1'b1;
      end else begin
        int b;
        logic e_oe;
        b = k / dv;
        e_oe = !(m_rd && b >= 46);
        check(idle == 1'b0, "R9", int'(idle), 0);
        check(mdc == ((k % dv) >= dv / 2), "R4", int'(mdc), int'((k % dv) >= dv / 2));
        check(mdio_oe == e_oe, m_rd ? "R7" : "R6", int'(mdio_oe), int'(e_oe));
        if (e_oe) check(mdio_o == m_frame[63 - b], "R5", int'(mdio_o), int'(m_frame[63 - b]));
        mdio_i = (b >= 48) ? phy_pat[15 - (b - 48)] : 1'b0;
      end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (!idle) @(negedge clk);
  endtask

  task automatic start(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] wd, input logic [1:0] rng);
    @(negedge clk);
    rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd; clk_range = rng;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(idle == 1'b1 && mdc == 1'b0 && mdio_oe == 1'b0, "R1",
          int'({idle, mdc, mdio_oe}), 4);
    check(rd_data == 16'h0, "R1", int'(rd_data), 0);
    rst = 1'b0;

    // R2: request with port disabled is ignored
    start(1'b0, 5'd3, 5'd4, 16'h1234, 2'd0);
    check(idle == 1'b1 && mdc == 1'b0, "R2", int'({idle, mdc}), 2);
    repeat (4) @(negedge clk);
    check(idle == 1'b1, "R2", int'(idle), 1);

    port_en = 1'b1;
    // R6: write at /8
    start(1'b0, 5'h15, 5'h0A, 16'hA5C3, 2'd0);
    check(idle == 1'b0, "R9", int'(idle), 0);
    wait_idle();
    check(rd_data == 16'h0, "R8", int'(rd_data), 0);

    // R8: read at /16
    phy_pat = 16'hBEEF;
    start(1'b1, 5'h01, 5'h1F, 16'hFFFF, 2'd1);
    repeat (100) @(negedge clk);
    // R3: request while busy is dropped
    start(1'b0, 5'h1F, 5'h00, 16'h0F0F, 2'd3);
    check(idle == 1'b0, "R3", int'(idle), 0);
    wait_idle();
    check(rd_data == 16'hBEEF, "R8", int'(rd_data), 16'hBEEF);

    // R4: write at /32, then read at /64
    start(1'b0, 5'h0C, 5'h13, 16'h8001, 2'd2);
    wait_idle();
    phy_pat = 16'h5A17;
    start(1'b1, 5'h1E, 5'h02, 16'h0000, 2'd3);
    wait_idle();
    check(rd_data == 16'h5A17, "R8", int'(rd_data), 16'h5A17);

    // write after read keeps rd_data (R8); back-to-back accept (R2)
    start(1'b0, 5'h00, 5'h00, 16'hFFFF, 2'd0);
    wait_idle();
    check(rd_data == 16'h5A17, "R8", int'(rd_data), 16'h5A17);
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule